// File: doc/BRIEF.md
# Single-Channel Fly-By Block Transfer Controller

This block moves a block of words between memory and one peripheral without the processor touching the data. Software first loads a start address, a word count and a direction through a small write-only configuration port, then sets a start bit. The channel is then armed and waits for the peripheral to ask for service.

When the peripheral asks, the controller requests the system bus and holds that request until the whole block is done. Once the bus owner grants the bus, the controller acknowledges the peripheral and runs a fixed three-cycle pattern for each word. The first cycle drives the address. The second asserts the read strobe of the source. The third keeps that read strobe and adds the write strobe of the destination, so the data passes directly from source to destination. After every word the address steps up and the count steps down. When the last word is written, the controller drops the bus request, sets a sticky completion flag and pulses an interrupt.

Top module: `dma_flyby_ctrl`

## Requirements
- R1: While reset is low and in the first cycle after reset, every strobe, `bus_req`, `dev_ack`, `busy`, `done` and `irq` is low and `mem_addr` is zero.
- R2: While idle, a configuration write takes effect in the next cycle. `cfg_sel` 0 loads the start address (seen at once on `mem_addr`). `cfg_sel` 1 loads the word count minus one from the low bits of `cfg_wdata`. `cfg_sel` 2 loads the direction from bit 0 and arms the channel if bit 1 is set; arming clears `done`. A control write with bit 1 clear does not arm the channel.
- R3: An armed channel raises `bus_req` one cycle after it samples `dev_req` high. `bus_req` stays high until the last word completes.
- R4: `dev_ack` rises one cycle after `bus_grant` is sampled high during the request phase and stays high through the last word. No strobe is active before `dev_ack`.
- R5: With direction 0 (memory to device), each word takes three cycles: the address alone, then `mem_rd`, then `mem_rd` together with `io_wr`.
- R6: With direction 1 (device to memory), each word takes three cycles: the address alone, then `io_rd`, then `io_rd` together with `mem_wr`.
- R7: After each word the address increments by one, wrapping modulo 2^AW. A programmed count of n moves exactly n+1 words, and `mem_addr` ends at start+n+1.
- R8: In the cycle after the last write strobe, `bus_req` and `dev_ack` are low, `done` is high and `irq` is high for exactly that one cycle. `done` then stays high until the channel is armed again.
- R9: A configuration write while `busy` is high is ignored, including one that falls in the final write cycle.
- R10: Once the channel samples `dev_req`, dropping `dev_req` does not cancel the request. `bus_req` holds for as long as `bus_grant` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Target: 0 address, 1 count, 2 control |
| cfg_wdata | input | AW | Configuration write data |
| dev_req | input | 1 | Peripheral service request |
| bus_grant | input | 1 | Bus granted by current owner |
| bus_req | output | 1 | Bus request, held for the whole block |
| dev_ack | output | 1 | Acknowledge to the peripheral |
| mem_addr | output | AW | Current memory address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| io_rd | output | 1 | Peripheral read strobe |
| io_wr | output | 1 | Peripheral write strobe |
| busy | output | 1 | Channel armed or transferring |
| done | output | 1 | Sticky completion flag |
| irq | output | 1 | One-cycle completion interrupt |

## Verification
Two events can fall in the same cycle: the final write cycle, which also completes the block, and a configuration write from software. The bench watches its reference model and drives an address write so that it is sampled exactly on the last word's write cycle. It also drives a count write of zero at the start of a long block. On every clock it compares the outputs against the model, which drops both writes. After each block it checks that the end address is start+n+1 and not the written value, and that the number of write strobes is still n+1.

// File: rtl/dma_pkg.sv
package dma_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_HOLD,
        ST_ADDR,
        ST_STRB1,
        ST_STRB2
    } dma_state_e;

    localparam logic [1:0] SEL_ADDR  = 2'd0;
    localparam logic [1:0] SEL_COUNT = 2'd1;
    localparam logic [1:0] SEL_CTRL  = 2'd2;

    localparam int CTRL_DIR_BIT   = 0;
    localparam int CTRL_START_BIT = 1;

    typedef struct packed {
        dma_state_e state;
        logic       done;
        logic       irq;
    } seq_regs_t;

endpackage

// File: rtl/dma_ptr_regs.sv
module dma_ptr_regs
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [1:0]    wr_sel,
    input  logic [AW-1:0] wr_data,
    input  logic          step,
    input  logic          busy,
    output logic [AW-1:0] addr,
    output logic          dir,
    output logic          tc
);

    localparam logic [AW-1:0] A_ONE = {{(AW-1){1'b0}}, 1'b1};
    localparam logic [CW-1:0] C_ONE = {{(CW-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [AW-1:0] addr;
        logic [CW-1:0] count;
        logic          dir;
    } ptr_t;

    ptr_t ptr_d, ptr_q;

    always_comb begin
        ptr_d = ptr_q;
        if (wr_en) begin
            case (wr_sel)
                SEL_ADDR:  ptr_d.addr  = wr_data;
                SEL_COUNT: ptr_d.count = wr_data[CW-1:0];
                SEL_CTRL:  ptr_d.dir   = wr_data[CTRL_DIR_BIT];
                default:   ;
            endcase
        end else if (step) begin
            ptr_d.addr  = ptr_q.addr + A_ONE;
            ptr_d.count = ptr_q.count - C_ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ptr_q <= '0;
        else        ptr_q <= ptr_d;
    end

    assign addr = ptr_q.addr;
    assign dir  = ptr_q.dir;
    assign tc   = (ptr_q.count == '0);

    // R7: every word advances the address and consumes one count
    p_step_addr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (ptr_q.addr == $past(ptr_q.addr) + A_ONE));
    p_step_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
        step |=> (ptr_q.count == $past(ptr_q.count) - C_ONE));
    // R9: programming is frozen while the channel is busy
    p_frozen_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !step) |=> ($stable(ptr_q.addr) && $stable(ptr_q.count) && $stable(ptr_q.dir)));

endmodule

// File: rtl/dma_seq.sv
module dma_seq
    import dma_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic dev_req,
    input  logic bus_grant,
    input  logic dir,
    input  logic tc,
    output logic bus_req,
    output logic dev_ack,
    output logic mem_rd,
    output logic mem_wr,
    output logic io_rd,
    output logic io_wr,
    output logic step,
    output logic busy,
    output logic done,
    output logic irq
);

    seq_regs_t seq_d, seq_q;
    logic      rd_phase, wr_phase;

    always_comb begin
        seq_d     = seq_q;
        seq_d.irq = 1'b0;
        case (seq_q.state)
            ST_IDLE: if (arm) begin
                seq_d.state = ST_WAIT;
                seq_d.done  = 1'b0;
            end
            ST_WAIT:  if (dev_req)   seq_d.state = ST_HOLD;
            ST_HOLD:  if (bus_grant) seq_d.state = ST_ADDR;
            ST_ADDR:  seq_d.state = ST_STRB1;
            ST_STRB1: seq_d.state = ST_STRB2;
            ST_STRB2: begin
                if (tc) begin
                    seq_d.state = ST_IDLE;
                    seq_d.done  = 1'b1;
                    seq_d.irq   = 1'b1;
                end else begin
                    seq_d.state = ST_ADDR;
                end
            end
            default: seq_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) seq_q <= '{state: ST_IDLE, done: 1'b0, irq: 1'b0};
        else        seq_q <= seq_d;
    end

    assign rd_phase = (seq_q.state == ST_STRB1) || (seq_q.state == ST_STRB2);
    assign wr_phase = (seq_q.state == ST_STRB2);
    assign dev_ack  = (seq_q.state == ST_ADDR) || rd_phase;
    assign bus_req  = (seq_q.state == ST_HOLD) || dev_ack;
    assign mem_rd   = rd_phase && !dir;
    assign io_rd    = rd_phase && dir;
    assign io_wr    = wr_phase && !dir;
    assign mem_wr   = wr_phase && dir;
    assign step     = wr_phase;
    assign busy     = (seq_q.state != ST_IDLE);
    assign done     = seq_q.done;
    assign irq      = seq_q.irq;

    // R3: bus request only follows a sampled peripheral request
    p_req_after_dev_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(bus_req) |-> $past(dev_req));
    // R4: acknowledge only follows a sampled grant
    p_ack_after_grant_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dev_ack) |-> $past(bus_grant));
    // R5: a write strobe always follows a read strobe cycle
    p_write_follows_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (io_wr || mem_wr) |-> $past(mem_rd || io_rd));
    // R8: interrupt is a single-cycle pulse
    p_irq_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);
    // R8: bus released together with the interrupt
    p_release_irq_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(bus_req) |-> irq);

endmodule

// File: rtl/dma_flyby_ctrl.sv
module dma_flyby_ctrl
    import dma_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [1:0]    cfg_sel,
    input  logic [AW-1:0] cfg_wdata,
    input  logic          dev_req,
    input  logic          bus_grant,
    output logic          bus_req,
    output logic          dev_ack,
    output logic [AW-1:0] mem_addr,
    output logic          mem_rd,
    output logic          mem_wr,
    output logic          io_rd,
    output logic          io_wr,
    output logic          busy,
    output logic          done,
    output logic          irq
);

    logic cfg_ok, arm, step, dir, tc;

    assign cfg_ok = cfg_we && !busy;
    assign arm    = cfg_ok && (cfg_sel == SEL_CTRL) && cfg_wdata[CTRL_START_BIT];

    dma_ptr_regs #(.AW(AW), .CW(CW)) u_ptr (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (cfg_ok),
        .wr_sel  (cfg_sel),
        .wr_data (cfg_wdata),
        .step    (step),
        .busy    (busy),
        .addr    (mem_addr),
        .dir     (dir),
        .tc      (tc)
    );

    dma_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .arm       (arm),
        .dev_req   (dev_req),
        .bus_grant (bus_grant),
        .dir       (dir),
        .tc        (tc),
        .bus_req   (bus_req),
        .dev_ack   (dev_ack),
        .mem_rd    (mem_rd),
        .mem_wr    (mem_wr),
        .io_rd     (io_rd),
        .io_wr     (io_wr),
        .step      (step),
        .busy      (busy),
        .done      (done),
        .irq       (irq)
    );

endmodule

// File: tb/dma_flyby_ctrl_tb.sv
module dma_flyby_ctrl_tb;

    localparam int AW = 16;
    localparam int CW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [1:0]    cfg_sel = 2'd0;
    logic [AW-1:0] cfg_wdata = '0;
    logic          dev_req = 1'b0;
    logic          bus_grant = 1'b0;
    logic          bus_req, dev_ack, mem_rd, mem_wr, io_rd, io_wr, busy, done, irq;
    logic [AW-1:0] mem_addr;

    always #4 clk = ~clk;

    dma_flyby_ctrl #(.AW(AW), .CW(CW)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .dev_req(dev_req), .bus_grant(bus_grant),
        .bus_req(bus_req), .dev_ack(dev_ack), .mem_addr(mem_addr),
        .mem_rd(mem_rd), .mem_wr(mem_wr), .io_rd(io_rd), .io_wr(io_wr),
        .busy(busy), .done(done), .irq(irq)
    );

    int vectors = 0;
    int fails   = 0;
    int cyc     = 0;
    int words   = 0;
    int irqs    = 0;

    task automatic chk1(input string tag, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic chkw(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Behavioural reference: phase 0 idle, 1 armed, 2 holding, 3 address, 4 read, 5 read+write
    int            m_ph   = 0;
    logic [AW-1:0] m_addr = '0;
    logic [CW-1:0] m_cnt  = '0;
    logic          m_dir  = 1'b0;
    logic          m_done = 1'b0;
    logic          m_irq  = 1'b0;

    always @(posedge clk) begin
        m_irq = 1'b0;
        if (!rst_n) begin
            m_ph = 0; m_addr = '0; m_cnt = '0; m_dir = 1'b0; m_done = 1'b0;
        end else begin
            case (m_ph)
                0: if (cfg_we) begin
                    if (cfg_sel == 2'd0) m_addr = cfg_wdata;
                    if (cfg_sel == 2'd1) m_cnt = cfg_wdata[CW-1:0];
                    if (cfg_sel == 2'd2) begin
                        m_dir = cfg_wdata[0];
                        if (cfg_wdata[1]) begin m_ph = 1; m_done = 1'b0; end
                    end
                end
                1: if (dev_req) m_ph = 2;
                2: if (bus_grant) m_ph = 3;
                3: m_ph = 4;
                4: m_ph = 5;
                default: begin
                    m_addr = m_addr + 1'b1;
                    if (m_cnt == 0) begin m_ph = 0; m_done = 1'b1; m_irq = 1'b1; end
                    else m_ph = 3;
                    m_cnt = m_cnt - 1'b1;
                end
            endcase
        end
    end

    task automatic summary_and_end();
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    endtask

    always @(negedge clk) begin
        cyc++;
        chk1("R3 bus_req",  bus_req, m_ph >= 2);
        chk1("R4 dev_ack",  dev_ack, m_ph >= 3);
        chk1("R5 mem_rd",   mem_rd,  !m_dir && (m_ph == 4 || m_ph == 5));
        chk1("R5 io_wr",    io_wr,   !m_dir && m_ph == 5);
        chk1("R6 io_rd",    io_rd,   m_dir && (m_ph == 4 || m_ph == 5));
        chk1("R6 mem_wr",   mem_wr,  m_dir && m_ph == 5);
        chkw("R7 mem_addr", 32'(mem_addr), 32'(m_addr));
        chk1("R9 busy",     busy,    m_ph != 0);
        chk1("R8 done",     done,    m_done);
        chk1("R8 irq",      irq,     m_irq);
        if (io_wr || mem_wr) words++;
        if (irq) irqs++;
        if (cyc > 150000) begin
            vectors++;
            fails++;
            $display("FAIL watchdog: got %0d cycles expected completion", cyc);
            summary_and_end();
        end
    end

    task automatic cfg_write(input logic [1:0] sel, input logic [AW-1:0] data);
        @(posedge clk); #1;
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = data;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    // coll: 0 none, 1 address write on final write cycle, 2 count write at first word
    task automatic run_xfer(input logic d, input logic [AW-1:0] a, input logic [CW-1:0] n,
                            input int gdly, input bit drop, input int coll);
        logic [AW-1:0] ea;
        bit injected;
        injected = 0;
        cfg_write(2'd0, a);
        cfg_write(2'd1, AW'(n));
        cfg_write(2'd2, {{(AW-2){1'b0}}, 1'b1, d});
        words = 0;
        irqs  = 0;
        repeat (2) @(posedge clk);
        #1 dev_req = 1'b1;
        if (drop) begin
            @(posedge clk); #1 dev_req = 1'b0;
            @(posedge clk); #1;
            chk1("R10 request held after dev_req drop", bus_req, 1'b1);
        end
        repeat (gdly) @(posedge clk);
        #1 bus_grant = 1'b1; dev_req = 1'b0;
        for (int g = 0; g < 4000; g++) begin
            @(posedge clk); #1;
            if (cfg_we) cfg_we = 1'b0;
            if (m_ph == 0) break;
            if (coll == 1 && m_ph == 5 && m_cnt == 0 && !injected) begin
                cfg_we = 1'b1; cfg_sel = 2'd0; cfg_wdata = 16'h7777; injected = 1;
            end
            if (coll == 2 && m_ph == 3 && !injected) begin
                cfg_we = 1'b1; cfg_sel = 2'd1; cfg_wdata = '0; injected = 1;
            end
        end
        bus_grant = 1'b0;
        @(posedge clk); #1;
        ea = a + AW'(n) + AW'(1);
        chkw("R7 words moved", 32'(words), 32'(n) + 32'd1);
        chkw("R8 irq pulses", 32'(irqs), 32'd1);
        chkw("R9 end address after busy write", 32'(mem_addr), 32'(ea));
        chk1("R8 done held", done, 1'b1);
        chk1("R8 bus released", bus_req, 1'b0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk1("R1 reset strobes", bus_req | dev_ack | mem_rd | mem_wr | io_rd | io_wr, 1'b0);
        chk1("R1 reset status", busy | done | irq, 1'b0);
        chkw("R1 reset address", 32'(mem_addr), 32'd0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk1("R1 first cycle idle", busy, 1'b0);

        // R2: control write without start bit must not arm
        cfg_write(2'd2, 16'h0001);
        dev_req = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk1("R2 no arm without start bit", bus_req, 1'b0);
        dev_req = 1'b0;
        cfg_write(2'd0, 16'h1234);
        chkw("R2 address load", 32'(mem_addr), 32'h1234);

        run_xfer(1'b0, 16'h0100, 8'd3,   3, 1'b0, 1);   // R5, R9 final-word collision
        run_xfer(1'b1, 16'h2000, 8'd0,   5, 1'b1, 0);   // R6, R10, single word
        run_xfer(1'b0, 16'hFFFE, 8'd255, 1, 1'b0, 2);   // R7 wrap, R9 mid-block write
        run_xfer(1'b1, 16'h0040, 8'd7,   2, 1'b0, 0);   // R6 multi-word
        cfg_write(2'd2, 16'h0002);
        chk1("R2 arming clears done", done, 1'b0);

        repeat (4) @(posedge clk);
        summary_and_end();
    end

endmodule